// File: doc/BRIEF.md
# Load/Store Watchpoint Comparator Unit

This block observes the data-side memory accesses of a processor core and decides, one instruction at a time, whether a programmed load/store watchpoint was hit. Each access is tested against two programmable address comparators and one data comparator. The address comparators apply alignment masking based on the access size. The data comparator has a per-byte-lane enable, so a byte or half-word value can be found inside a wider access. Software chooses whether loads, stores or both are watched. A store is compared on the data after the byte swap, and a load on the raw bus data before its swap.

A hit is not reported at the access itself. It is held in a pending flag until the core strobes `retire` for the owning instruction. At most one watchpoint event is then issued, even when a multiple or string transfer matched several times. With the event, the block can raise a breakpoint request, which can be suppressed by a mask input. It latches the address of the first matching access and steps a loadable down-counter that flags expiry at zero.

The control core is a two-state machine. In `ST_IDLE` no match is pending. The transition IDLE→PEND is taken on a matching access without `retire`, and it latches that access address. The transition PEND→IDLE is taken on `retire`, and it fires the event. In ST_IDLE, a matching access together with `retire` fires directly and stays in ST_IDLE. Every other case holds the current state.

Top module: `lsw_watch_unit`

## Requirements
- R1: Address masking follows the access size, coded on `acc_size` as 0 = byte, 1 = half-word, 2 = word (3 is treated as byte). A word access ignores address bits [1:0] of both operands. A half-word access ignores bit [0]. A byte access compares all bits.
- R2: The data comparator checks lane i (bits 8i+7..8i) only where `dat_lane_en[i]` is 1. The data test passes when every enabled lane is equal. When `dat_en` is 0, the data test always passes.
- R3: A store (`acc_store`=1) is compared on `st_data`, and a load on `ld_data`. A store is watched only when `dir_sel[1]` is 1, and a load only when `dir_sel[0]` is 1.
- R4: Each address comparator evaluates its condition as access address versus reference. The codes are 0 = equal, 1 = not equal, 2 = greater than, 3 = less than. `addr_comb` selects the combined address test: 0 = comparator A alone, 1 = A and B (in range), 2 = A or B (out of range), 3 = address ignored.
- R5: `wp_event` pulses for one cycle, in the cycle after a `retire` cycle, if at least one access matched since the previous retire. The retire cycle itself counts as part of this window.
- R6: However many accesses of one instruction match, only one event is issued for that instruction.
- R7: `bp_addr` takes the full address of the first matching access of the instruction, in the same cycle as the event. It holds its value otherwise.
- R8: `bp_req` pulses together with `wp_event` when `bp_en` is 1. It is suppressed when `bp_maskable` and `bp_mask_in` are both 1 in the retire cycle.
- R9: The 16-bit counter loads `cnt_load_val` on `cnt_load`, which has priority and clears the expiry flag. Otherwise it decrements by one per event while it is non-zero. `cnt_expired` sets when a decrement reaches zero. The counter stays at zero afterwards.
- R10: After reset, `wp_event`, `bp_req`, `bp_addr`, `cnt_val` and `cnt_expired` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_valid | input | 1 | A data access is present this cycle |
| acc_addr | input | 32 | Access address |
| acc_size | input | 2 | 0 byte, 1 half-word, 2 word |
| acc_store | input | 1 | 1 store, 0 load |
| st_data | input | 32 | Store data after byte swap |
| ld_data | input | 32 | Load data before byte swap |
| retire | input | 1 | Owning instruction retires this cycle |
| cmp_a_addr | input | 32 | Reference of address comparator A |
| cmp_a_cond | input | 2 | Condition of comparator A |
| cmp_b_addr | input | 32 | Reference of address comparator B |
| cmp_b_cond | input | 2 | Condition of comparator B |
| addr_comb | input | 2 | Combination of A and B |
| dat_en | input | 1 | Enable the data test |
| dat_ref | input | 32 | Data reference value |
| dat_lane_en | input | 4 | Per-byte-lane compare enable |
| dir_sel | input | 2 | Bit0 watch loads, bit1 watch stores |
| bp_en | input | 1 | Breakpoint request enable |
| bp_maskable | input | 1 | Breakpoint obeys the mask input |
| bp_mask_in | input | 1 | Breakpoint mask |
| cnt_load | input | 1 | Load the event counter |
| cnt_load_val | input | 16 | Counter load value |
| wp_event | output | 1 | Watchpoint event pulse |
| bp_req | output | 1 | Breakpoint request pulse |
| bp_addr | output | 32 | Captured breakpoint address |
| cnt_val | output | 16 | Event counter value |
| cnt_expired | output | 1 | Counter reached zero by decrement |

## Verification
The address and data tests are combinational, but they only become visible after the next rising edge. `wp_event`, `bp_req`, `bp_addr`, the counter and its flag all update on the edge that closes the `retire` cycle, so each is due exactly one cycle after that retire. `cnt_load` likewise takes effect one cycle later. The bench drives on the falling edge and updates its behavioural model on the rising edge. It compares every output at the following falling edge, so each expected value is sampled in the first cycle it is due and is not re-checked on a stale edge. A separate event tally covers the once-per-instruction rule across multi-transfer instructions.

// File: rtl/lsw_pkg.sv
package lsw_pkg;
    typedef enum logic [1:0] {SZ_BYTE = 2'd0, SZ_HALF = 2'd1, SZ_WORD = 2'd2, SZ_RSVD = 2'd3} acc_size_e;
    typedef enum logic [1:0] {CND_EQ = 2'd0, CND_NE = 2'd1, CND_GT = 2'd2, CND_LT = 2'd3} cond_e;
    typedef enum logic [1:0] {CMB_A = 2'd0, CMB_AND = 2'd1, CMB_OR = 2'd2, CMB_ANY = 2'd3} comb_e;
    typedef enum logic {ST_IDLE = 1'b0, ST_PEND = 1'b1} wp_state_e;
endpackage

// File: rtl/lsw_addr_cmp.sv
module lsw_addr_cmp
    import lsw_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic [AW-1:0] addr,
    input  logic [AW-1:0] ref_addr,
    input  acc_size_e     size,
    input  cond_e         cond,
    output logic          hit
);
    logic [AW-1:0] keep;
    logic [AW-1:0] a_m;
    logic [AW-1:0] r_m;

    always_comb begin
        keep = '1;
        case (size)
            SZ_WORD: keep[1:0] = 2'b00;
            SZ_HALF: keep[0]   = 1'b0;
            default: ;
        endcase
        a_m = addr & keep;
        r_m = ref_addr & keep;
        unique case (cond)
            CND_EQ: hit = (a_m == r_m);
            CND_NE: hit = (a_m != r_m);
            CND_GT: hit = (a_m >  r_m);
            CND_LT: hit = (a_m <  r_m);
        endcase
    end
endmodule

// File: rtl/lsw_data_cmp.sv
module lsw_data_cmp #(
    parameter int DW = 32,
    localparam int LANES = DW / 8
) (
    input  logic [DW-1:0]    data,
    input  logic [DW-1:0]    ref_data,
    input  logic [LANES-1:0] lane_en,
    input  logic             en,
    output logic             hit
);
    logic [LANES-1:0] lane_ok;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign lane_ok[i] = !lane_en[i] || (data[8*i +: 8] == ref_data[8*i +: 8]);
    end

    assign hit = !en || (&lane_ok);
endmodule

// File: rtl/lsw_event_fsm.sv
module lsw_event_fsm
    import lsw_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          acc_hit,
    input  logic [AW-1:0] acc_addr,
    input  logic          retire,
    input  logic          bp_en,
    input  logic          bp_maskable,
    input  logic          bp_mask_in,
    output logic          fire,
    output logic          wp_event,
    output logic          bp_req,
    output logic [AW-1:0] bp_addr
);
    wp_state_e     state_q, state_d;
    logic [AW-1:0] held_q;
    logic [AW-1:0] ev_addr;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (acc_hit && !retire) state_d = ST_PEND;
            ST_PEND: if (retire)             state_d = ST_IDLE;
        endcase
    end

    assign fire    = retire && ((state_q == ST_PEND) || acc_hit);
    assign ev_addr = (state_q == ST_PEND) ? held_q : acc_addr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            held_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && acc_hit) held_q <= acc_addr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp_event <= 1'b0;
            bp_req   <= 1'b0;
            bp_addr  <= '0;
        end else begin
            wp_event <= fire;
            bp_req   <= fire && bp_en && !(bp_maskable && bp_mask_in);
            if (fire) bp_addr <= ev_addr;
        end
    end
endmodule

// File: rtl/lsw_counter.sv
module lsw_counter #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          dec,
    output logic [CW-1:0] cnt,
    output logic          expired
);
    localparam logic [CW-1:0] ONE = CW'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            expired <= 1'b0;
        end else if (load) begin
            cnt     <= load_val;
            expired <= 1'b0;
        end else if (dec && cnt != '0) begin
            cnt <= cnt - ONE;
            if (cnt == ONE) expired <= 1'b1;
        end
    end
endmodule

// File: rtl/lsw_watch_unit.sv
module lsw_watch_unit
    import lsw_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int CW = 16,
    localparam int LANES = DW / 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_valid,
    input  logic [AW-1:0]    acc_addr,
    input  logic [1:0]       acc_size,
    input  logic             acc_store,
    input  logic [DW-1:0]    st_data,
    input  logic [DW-1:0]    ld_data,
    input  logic             retire,
    input  logic [AW-1:0]    cmp_a_addr,
    input  logic [1:0]       cmp_a_cond,
    input  logic [AW-1:0]    cmp_b_addr,
    input  logic [1:0]       cmp_b_cond,
    input  logic [1:0]       addr_comb,
    input  logic             dat_en,
    input  logic [DW-1:0]    dat_ref,
    input  logic [LANES-1:0] dat_lane_en,
    input  logic [1:0]       dir_sel,
    input  logic             bp_en,
    input  logic             bp_maskable,
    input  logic             bp_mask_in,
    input  logic             cnt_load,
    input  logic [CW-1:0]    cnt_load_val,
    output logic             wp_event,
    output logic             bp_req,
    output logic [AW-1:0]    bp_addr,
    output logic [CW-1:0]    cnt_val,
    output logic             cnt_expired
);
    logic          a_hit, b_hit, addr_ok, data_ok, dir_ok, acc_hit, fire;
    logic [DW-1:0] cmp_data;

    lsw_addr_cmp #(.AW(AW)) u_cmp_a (
        .addr(acc_addr), .ref_addr(cmp_a_addr), .size(acc_size_e'(acc_size)),
        .cond(cond_e'(cmp_a_cond)), .hit(a_hit)
    );

    lsw_addr_cmp #(.AW(AW)) u_cmp_b (
        .addr(acc_addr), .ref_addr(cmp_b_addr), .size(acc_size_e'(acc_size)),
        .cond(cond_e'(cmp_b_cond)), .hit(b_hit)
    );

    always_comb begin
        unique case (comb_e'(addr_comb))
            CMB_A:   addr_ok = a_hit;
            CMB_AND: addr_ok = a_hit && b_hit;
            CMB_OR:  addr_ok = a_hit || b_hit;
            CMB_ANY: addr_ok = 1'b1;
        endcase
    end

    assign cmp_data = acc_store ? st_data : ld_data;
    assign dir_ok   = acc_store ? dir_sel[1] : dir_sel[0];

    lsw_data_cmp #(.DW(DW)) u_data (
        .data(cmp_data), .ref_data(dat_ref), .lane_en(dat_lane_en),
        .en(dat_en), .hit(data_ok)
    );

    assign acc_hit = acc_valid && dir_ok && addr_ok && data_ok;

    lsw_event_fsm #(.AW(AW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .acc_hit(acc_hit), .acc_addr(acc_addr),
        .retire(retire), .bp_en(bp_en), .bp_maskable(bp_maskable),
        .bp_mask_in(bp_mask_in), .fire(fire), .wp_event(wp_event),
        .bp_req(bp_req), .bp_addr(bp_addr)
    );

    lsw_counter #(.CW(CW)) u_cnt (
        .clk(clk), .rst_n(rst_n), .load(cnt_load), .load_val(cnt_load_val),
        .dec(fire), .cnt(cnt_val), .expired(cnt_expired)
    );
endmodule

// File: rtl/lsw_watch_checker.sv
module lsw_watch_checker #(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          retire,
    input logic          bp_maskable,
    input logic          bp_mask_in,
    input logic          cnt_load,
    input logic          wp_event,
    input logic          bp_req,
    input logic [AW-1:0] bp_addr,
    input logic [CW-1:0] cnt_val,
    input logic          cnt_expired
);
    p_event_after_retire_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wp_event |-> $past(retire));

    p_bp_with_event_r8: assert property (@(posedge clk) disable iff (!rst_n)
        bp_req |-> wp_event);

    p_masked_bp_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (retire && bp_maskable && bp_mask_in) |=> !bp_req);

    p_addr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !wp_event |-> $stable(bp_addr));

    p_count_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wp_event && !$past(cnt_load) && $past(cnt_val) != '0)
            |-> cnt_val == $past(cnt_val) - CW'(1));

    p_expired_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_expired |-> cnt_val == '0);
endmodule

bind lsw_watch_unit lsw_watch_checker #(.AW(AW), .CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .retire(retire), .bp_maskable(bp_maskable),
    .bp_mask_in(bp_mask_in), .cnt_load(cnt_load), .wp_event(wp_event),
    .bp_req(bp_req), .bp_addr(bp_addr), .cnt_val(cnt_val), .cnt_expired(cnt_expired)
);

// File: tb/lsw_watch_unit_bench.sv
`timescale 1ns/1ps
module lsw_watch_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 0, acc_store = 0, retire = 0;
    logic [31:0] acc_addr = 0, st_data = 0, ld_data = 0;
    logic [1:0]  acc_size = 0;
    logic [31:0] cmp_a_addr = 0, cmp_b_addr = 0, dat_ref = 0;
    logic [1:0]  cmp_a_cond = 0, cmp_b_cond = 0, addr_comb = 0, dir_sel = 2'b11;
    logic        dat_en = 0, bp_en = 0, bp_maskable = 0, bp_mask_in = 0, cnt_load = 0;
    logic [3:0]  dat_lane_en = 0;
    logic [15:0] cnt_load_val = 0;
    logic        wp_event, bp_req, cnt_expired;
    logic [31:0] bp_addr;
    logic [15:0] cnt_val;

    lsw_watch_unit u_lsw_watch_unit (.*);

    always #5 clk = ~clk;

    int    errors = 0, checks = 0, cyc = 0, ev_tally = 0;
    string cur_req = "R10";

    // behavioural reference state
    bit        m_pend = 0, m_ev = 0, m_bp = 0, m_exp = 0;
    bit [31:0] m_paddr = 0, m_bpaddr = 0;
    int        m_cnt = 0;

    function automatic bit cond_ok(longint a, longint c, bit [1:0] cd);
        case (cd)
            2'd0: return a == c;
            2'd1: return a != c;
            2'd2: return a > c;
            default: return a < c;
        endcase
    endfunction

    function automatic bit ref_match();
        int  sh;
        bit  ah, bh, ad, dd;
        bit [31:0] d;
        if (!acc_valid) return 0;
        if (acc_store ? !dir_sel[1] : !dir_sel[0]) return 0;
        sh = (acc_size == 2) ? 2 : (acc_size == 1) ? 1 : 0;
        ah = cond_ok(acc_addr >> sh, cmp_a_addr >> sh, cmp_a_cond);
        bh = cond_ok(acc_addr >> sh, cmp_b_addr >> sh, cmp_b_cond);
        case (addr_comb)
            2'd0: ad = ah;
            2'd1: ad = ah & bh;
            2'd2: ad = ah | bh;
            default: ad = 1;
        endcase
        d  = acc_store ? st_data : ld_data;
        dd = 1;
        if (dat_en)
            for (int i = 0; i < 4; i++)
                if (dat_lane_en[i] && d[8*i +: 8] != dat_ref[8*i +: 8]) dd = 0;
        return ad & dd;
    endfunction

    always @(posedge clk) begin
        bit m, f;
        cyc++;
        if (!rst_n) begin
            m_pend = 0; m_ev = 0; m_bp = 0; m_exp = 0; m_paddr = 0; m_bpaddr = 0; m_cnt = 0;
        end else begin
            m = ref_match();
            f = retire && (m_pend || m);
            m_ev = f;
            m_bp = f && bp_en && !(bp_maskable && bp_mask_in);
            if (f) m_bpaddr = m_pend ? m_paddr : acc_addr;
            if (retire) m_pend = 0;
            else if (m && !m_pend) begin m_pend = 1; m_paddr = acc_addr; end
            if (cnt_load) begin m_cnt = cnt_load_val; m_exp = 0; end
            else if (f && m_cnt > 0) begin m_cnt--; if (m_cnt == 0) m_exp = 1; end
        end
        if (cyc > 20000) begin
            errors++; checks++;
            $display("FAIL watchdog: run hung, actual cyc=%0d expected <=20000", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic cmp1(string nm, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", cur_req, nm, act, exp);
        end
    endtask

    always @(negedge clk) begin
        cmp1("wp_event", wp_event, m_ev);
        cmp1("bp_req", bp_req, m_bp);
        cmp1("bp_addr", bp_addr, m_bpaddr);
        cmp1("cnt_val", cnt_val, m_cnt);
        cmp1("cnt_expired", cnt_expired, m_exp);
        if (wp_event) ev_tally++;
    end

    task automatic acc(input bit [31:0] a, input bit [1:0] sz, input bit st,
                       input bit [31:0] sd, input bit [31:0] ldv, input bit ret);
        @(negedge clk);
        acc_valid = 1; acc_addr = a; acc_size = sz; acc_store = st;
        st_data = sd; ld_data = ldv; retire = ret; cnt_load = 0;
    endtask

    task automatic quiet(input int n);
        repeat (n) begin
            @(negedge clk);
            acc_valid = 0; retire = 0; cnt_load = 0;
        end
    endtask

    task automatic ret_only();
        @(negedge clk);
        acc_valid = 0; retire = 1; cnt_load = 0;
    endtask

    initial begin
        // R10: reset values observed during reset
        repeat (3) @(negedge clk);
        rst_n = 1;
        quiet(2);

        // R1: address masking by access size
        cur_req = "R1";
        cmp_a_addr = 32'h1000; cmp_a_cond = 2'd0; addr_comb = 2'd0;
        acc(32'h1002, 2'd2, 0, 0, 0, 1); quiet(1);   // word, hit
        acc(32'h1002, 2'd0, 0, 0, 0, 1); quiet(1);   // byte, miss
        acc(32'h1001, 2'd1, 0, 0, 0, 1); quiet(1);   // half, hit
        acc(32'h1002, 2'd1, 0, 0, 0, 1); quiet(1);   // half, miss
        acc(32'h1000, 2'd0, 0, 0, 0, 1); quiet(1);   // byte, hit

        // R2: byte lane matching in a word load
        cur_req = "R2";
        dat_en = 1; dat_lane_en = 4'b0100; dat_ref = 32'h00AB_0000;
        acc(32'h1000, 2'd2, 0, 0, 32'h12AB_3456, 1); quiet(1);
        acc(32'h1000, 2'd2, 0, 0, 32'h12AC_3456, 1); quiet(1);
        dat_lane_en = 4'b0011; dat_ref = 32'h0000_BEEF;
        acc(32'h1000, 2'd2, 0, 0, 32'hFFFF_BEEF, 1); quiet(1);
        acc(32'h1000, 2'd2, 0, 0, 32'hFFFF_BEEE, 1); quiet(1);

        // R3: store/load data source and direction select
        cur_req = "R3";
        acc(32'h1000, 2'd2, 1, 32'h0000_BEEF, 32'h0, 1); quiet(1);   // store hit
        acc(32'h1000, 2'd2, 1, 32'h0, 32'h0000_BEEF, 1); quiet(1);   // store miss
        dir_sel = 2'b10;
        acc(32'h1000, 2'd2, 0, 0, 32'h0000_BEEF, 1); quiet(1);       // load ignored
        dir_sel = 2'b01;
        acc(32'h1000, 2'd2, 1, 32'h0000_BEEF, 0, 1); quiet(1);       // store ignored
        dir_sel = 2'b11; dat_en = 0;

        // R4: conditions and combinations
        cur_req = "R4";
        cmp_a_addr = 32'h2000; cmp_a_cond = 2'd2; cmp_b_addr = 32'h3000; cmp_b_cond = 2'd3;
        addr_comb = 2'd1;
        acc(32'h2800, 2'd0, 0, 0, 0, 1); quiet(1);
        acc(32'h3800, 2'd0, 0, 0, 0, 1); quiet(1);
        acc(32'h2003, 2'd2, 0, 0, 0, 1); quiet(1);    // masked to 0x2000, not greater
        cmp_a_cond = 2'd3; cmp_b_cond = 2'd2; addr_comb = 2'd2;
        acc(32'h2800, 2'd0, 0, 0, 0, 1); quiet(1);
        acc(32'h1800, 2'd0, 0, 0, 0, 1); quiet(1);
        acc(32'h3801, 2'd0, 0, 0, 0, 1); quiet(1);
        cmp_a_cond = 2'd1; addr_comb = 2'd0;
        acc(32'h2000, 2'd0, 0, 0, 0, 1); quiet(1);
        acc(32'h2004, 2'd0, 0, 0, 0, 1); quiet(1);
        addr_comb = 2'd3;
        acc(32'hDEAD_0000, 2'd0, 0, 0, 0, 1); quiet(1);

        // R5: no event before retire, event due one cycle after retire
        cur_req = "R5";
        cmp_a_addr = 32'h4000; cmp_a_cond = 2'd0; addr_comb = 2'd0;
        acc(32'h4000, 2'd2, 0, 0, 0, 0); quiet(3); ret_only(); quiet(2);
        acc(32'h5000, 2'd2, 0, 0, 0, 0); ret_only(); quiet(2);

        // R6 and R7: multi-transfer instruction yields one event, first address
        cur_req = "R6";
        addr_comb = 2'd3;
        ev_tally = 0;
        acc(32'h6000, 2'd2, 1, 0, 0, 0);
        acc(32'h6004, 2'd2, 1, 0, 0, 0);
        acc(32'h6008, 2'd2, 1, 0, 0, 1);
        quiet(2);
        checks++;
        if (ev_tally != 1) begin
            errors++;
            $display("FAIL R6 events per instruction: actual=%0d expected=1", ev_tally);
        end
        cur_req = "R7";
        checks++;
        if (bp_addr !== 32'h6000) begin
            errors++;
            $display("FAIL R7 bp_addr: actual=%0h expected=6000", bp_addr);
        end
        addr_comb = 2'd0; cmp_a_addr = 32'h7008;
        acc(32'h7000, 2'd2, 0, 0, 0, 0);
        acc(32'h7008, 2'd2, 0, 0, 0, 0);
        acc(32'h700A, 2'd2, 0, 0, 0, 0);
        ret_only(); quiet(2);

        // R8: breakpoint request and masking
        cur_req = "R8";
        addr_comb = 2'd3; bp_en = 1;
        acc(32'h8000, 2'd2, 0, 0, 0, 1); quiet(1);
        bp_maskable = 1; bp_mask_in = 1;
        acc(32'h8004, 2'd2, 0, 0, 0, 1); quiet(1);
        bp_maskable = 0;
        acc(32'h8008, 2'd2, 0, 0, 0, 1); quiet(1);
        bp_en = 0; bp_mask_in = 0;
        acc(32'h800C, 2'd2, 0, 0, 0, 1); quiet(1);

        // R9: counter load, decrement, expiry, saturation, load priority
        cur_req = "R9";
        @(negedge clk); acc_valid = 0; retire = 0; cnt_load = 1; cnt_load_val = 16'd2;
        quiet(1);
        acc(32'h9000, 2'd2, 0, 0, 0, 1); quiet(1);
        acc(32'h9000, 2'd2, 0, 0, 0, 1); quiet(1);
        acc(32'h9000, 2'd2, 0, 0, 0, 1); quiet(1);
        acc(32'h9000, 2'd2, 0, 0, 0, 1); cnt_load = 1; cnt_load_val = 16'd5;
        quiet(2);
        acc(32'h9000, 2'd2, 0, 0, 0, 1); quiet(2);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule